// File: doc/BRIEF.md
# Sequential DMA Channel Engine

This block is a single DMA channel that runs only in sequential mode. Software programs a 24-bit memory address, a 16-bit I/O-side address, a 16-bit transfer count and a small control word through a register write port. Each pulse on the transfer-request input moves one byte or one 16-bit word between the memory address and the I/O-side address. The channel does this as a read bus cycle from the source followed by a write bus cycle to the destination. The I/O-side address always lies in the top 64 KiB page: its upper eight bits are all ones, and it never changes during a run.

After each write completes, the memory address steps up or down by the transfer size and the count drops by one. When the count runs out, the channel disables itself and pulses a completion flag. If a request arrives while a transfer is still running, it is remembered as one pending request, so it is not lost. The block is a bus master with a request/acknowledge handshake: a bus cycle stays on the bus until the acknowledge is seen.

Top module: `dmaSeqEngine`

## Requirements
- R1: With the direction bit at 0, each transfer reads from the memory address and writes to the I/O-side address.
- R2: With the direction bit at 1, each transfer reads from the I/O-side address and writes to the memory address.
- R3: The I/O-side bus address is the programmed 16-bit value with bits 23..16 forced to 0xFF, and it stays the same for every transfer of a run.
- R4: After each transfer the memory address moves by 1 when the size bit is 0 (byte) and by 2 when it is 1 (word).
- R5: The memory address rises when the step-down bit is 0 and falls when it is 1, wrapping modulo 2^24.
- R6: The write cycle drives the data captured in the read cycle; in byte mode only bits 7..0 carry the byte.
- R7: A count of N gives exactly N transfers. On the edge after the last write acknowledge, the enable flag reads 0 and the completion pulse is high for exactly one cycle.
- R8: While the channel is disabled, transfer requests are ignored and start no bus cycle.
- R9: Any number of requests that arrive during a running transfer produce exactly one further transfer.
- R10: A bus cycle keeps its request, address and write flag unchanged until it is acknowledged, and an acknowledged read is always followed at once by its write.
- R11: After reset there is no bus request, the enable flag is 0 and the completion pulse is low.
- R12: Register select codes are 0 = memory address (24 bits), 1 = I/O-side address (bits 15..0), 2 = count (bits 15..0), 3 = control. In the control word, bit 0 is enable, bit 1 is direction, bit 2 is word size and bit 3 is step-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | 24 | Register write data |
| xferReq | input | 1 | Transfer request pulse |
| busReq | output | 1 | Bus cycle request |
| busWe | output | 1 | Bus cycle is a write |
| busWord | output | 1 | Bus cycle is 16 bits wide |
| busAddr | output | 24 | Bus address |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data |
| busAck | input | 1 | Bus cycle acknowledge |
| chanEn | output | 1 | Channel enable flag |
| xferEnd | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every combination of direction, size and step direction. The start addresses are chosen so that runs cross the 24-bit wrap both upward and downward. A design with the wrong carry width or the wrong step size would produce a wrong address on the very transfer that crosses the wrap. The bench acknowledges bus cycles after a varying number of wait cycles, so a design that moves on before the acknowledge would show up as a misplaced read or write. Extra requests are sent while a transfer is running and again after completion. A design that counts each pending request, drops the pending request, or keeps running after reaching zero would make the wrong number of bus cycles.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;
  typedef enum logic [1:0] {
    SEL_MEMADDR = 2'd0,
    SEL_IOADDR  = 2'd1,
    SEL_COUNT   = 2'd2,
    SEL_CTRL    = 2'd3
  } regSel_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_DIR  = 1;
  localparam int CTRL_WORD = 2;
  localparam int CTRL_DEC  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } chanState_e;

  typedef struct packed {
    logic latchData;
    logic stepAddr;
    logic writePhase;
  } dpStrobe_t;
endpackage

// File: rtl/dmaSeqDatapath.sv
module dmaSeqDatapath
  import dmaSeqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busRdata,
  output logic              countIsLast,
  output logic              wordSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);
  localparam int PAD_W = ADDR_W - IO_W;

  logic [ADDR_W-1:0] memAddr;
  logic [IO_W-1:0]   ioAddr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] dataBuf;
  logic              cfgDir, cfgWord, cfgDec;
  logic [ADDR_W-1:0] ioFull, stepAmt, nextAddr, srcAddr, dstAddr;

  generate
    if (PAD_W > 0) begin : gPad
      assign ioFull = {{PAD_W{1'b1}}, ioAddr};
    end else begin : gNoPad
      assign ioFull = ioAddr[ADDR_W-1:0];
    end
  endgenerate

  assign stepAmt  = cfgWord ? ADDR_W'(2) : ADDR_W'(1);
  assign nextAddr = cfgDec ? (memAddr - stepAmt) : (memAddr + stepAmt);
  assign srcAddr  = cfgDir ? ioFull : memAddr;
  assign dstAddr  = cfgDir ? memAddr : ioFull;

  assign busAddr     = strobe.writePhase ? dstAddr : srcAddr;
  assign busWdata    = dataBuf;
  assign wordSize    = cfgWord;
  assign countIsLast = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      ioAddr  <= '0;
      count   <= '0;
      dataBuf <= '0;
      cfgDir  <= 1'b0;
      cfgWord <= 1'b0;
      cfgDec  <= 1'b0;
    end else begin
      if (regWe) begin
        unique case (regSel_e'(regSel))
          SEL_MEMADDR: memAddr <= regWdata;
          SEL_IOADDR:  ioAddr  <= regWdata[IO_W-1:0];
          SEL_COUNT:   count   <= regWdata[CNT_W-1:0];
          SEL_CTRL: begin
            cfgDir  <= regWdata[CTRL_DIR];
            cfgWord <= regWdata[CTRL_WORD];
            cfgDec  <= regWdata[CTRL_DEC];
          end
          default: ;
        endcase
      end
      if (strobe.latchData) dataBuf <= busRdata;
      if (strobe.stepAddr) begin
        memAddr <= nextAddr;
        count   <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dmaSeqControl.sv
module dmaSeqControl
  import dmaSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWrite,
  input  logic      ctrlEnBit,
  input  logic      xferReq,
  input  logic      busAck,
  input  logic      countIsLast,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      busWe,
  output logic      chanEn,
  output logic      xferEnd
);
  chanState_e state, stateNext;
  logic pending, pendingNext, enNext;
  logic reqSeen, startXfer, finishXfer, lastXfer;

  assign reqSeen    = xferReq & chanEn;
  assign startXfer  = (state == ST_IDLE) & pending & chanEn;
  assign finishXfer = (state == ST_WRITE) & busAck;
  assign lastXfer   = finishXfer & countIsLast;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startXfer) stateNext = ST_READ;
      ST_READ:  if (busAck) stateNext = ST_WRITE;
      ST_WRITE: if (busAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase

    if (ctrlWrite || lastXfer) pendingNext = 1'b0;
    else if (startXfer)        pendingNext = reqSeen;
    else                       pendingNext = pending | reqSeen;

    if (ctrlWrite)     enNext = ctrlEnBit;
    else if (lastXfer) enNext = 1'b0;
    else               enNext = chanEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      chanEn  <= 1'b0;
      xferEnd <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendingNext;
      chanEn  <= enNext;
      xferEnd <= lastXfer;
    end
  end

  assign strobe.latchData  = (state == ST_READ) & busAck;
  assign strobe.stepAddr   = finishXfer;
  assign strobe.writePhase = (state == ST_WRITE);
  assign busReq = (state != ST_IDLE);
  assign busWe  = (state == ST_WRITE);
endmodule

// File: rtl/dmaSeqEngine.sv
module dmaSeqEngine
  import dmaSeqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              xferReq,
  output logic              busReq,
  output logic              busWe,
  output logic              busWord,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  output logic              chanEn,
  output logic              xferEnd
);
  dpStrobe_t strobe;
  logic countIsLast;
  logic ctrlWrite;

  assign ctrlWrite = regWe & (regSel == SEL_CTRL);

  dmaSeqControl uCtl (
    .clk(clk), .rstN(rstN),
    .ctrlWrite(ctrlWrite), .ctrlEnBit(regWdata[CTRL_EN]),
    .xferReq(xferReq), .busAck(busAck), .countIsLast(countIsLast),
    .strobe(strobe), .busReq(busReq), .busWe(busWe),
    .chanEn(chanEn), .xferEnd(xferEnd)
  );

  dmaSeqDatapath #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .strobe(strobe), .busRdata(busRdata),
    .countIsLast(countIsLast), .wordSize(busWord),
    .busAddr(busAddr), .busWdata(busWdata)
  );
endmodule

// File: rtl/dmaSeqChecker.sv
module dmaSeqChecker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWe,
  input logic              busAck,
  input logic [ADDR_W-1:0] busAddr,
  input logic              chanEn,
  input logic              xferEnd
);
  assert_read_then_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWe && busAck) |=> (busReq && busWe));

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWe)));

  assert_end_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |=> !xferEnd);

  assert_end_disables_R7: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> !chanEn);

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!chanEn && !busReq) |=> !busReq);
endmodule

bind dmaSeqEngine dmaSeqChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAck(busAck),
  .busAddr(busAddr), .chanEn(chanEn), .xferEnd(xferEnd)
);

// File: tb/sim_dmaSeqEngine.sv
`timescale 1ns/1ps
module sim_dmaSeqEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [23:0] regWdata = '0;
  logic        xferReq = 1'b0;
  logic        busReq, busWe, busWord, chanEn, xferEnd;
  logic [23:0] busAddr;
  logic [15:0] busWdata;
  logic [15:0] busRdata = '0;
  logic        busAck = 1'b0;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [23:0] logAddr [0:63];
  logic        logWe   [0:63];
  logic [15:0] logData [0:63];
  int logN = 0;
  int endPulses = 0;
  int endDouble = 0;
  int holdErrs = 0;
  int ackCount = 0;

  always #10 clk = ~clk;

  dmaSeqEngine u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .xferReq(xferReq), .busReq(busReq), .busWe(busWe), .busWord(busWord),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .chanEn(chanEn), .xferEnd(xferEnd)
  );

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[23:16]} ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responder and monitor
  initial begin
    int waitCnt = 0;
    logic prevReq = 1'b0, prevAck = 1'b0, prevWe = 1'b0, prevEnd = 1'b0;
    logic [23:0] prevAddr = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (prevReq && !prevAck && busReq && (busAddr !== prevAddr || busWe !== prevWe))
          holdErrs++;
        if (xferEnd) endPulses++;
        if (xferEnd && prevEnd) endDouble++;
      end
      prevEnd = xferEnd;
      busAck = 1'b0;
      if (rstN && busReq) begin
        if (waitCnt >= (ackCount % 3)) begin
          busAck = 1'b1;
          busRdata = pat(busAddr);
          if (logN < 64) begin
            logAddr[logN] = busAddr;
            logWe[logN]   = busWe;
            logData[logN] = busWdata;
          end
          logN++;
          ackCount++;
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
      prevReq = busReq; prevAck = busAck; prevWe = busWe; prevAddr = busAddr;
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk);
    xferReq = 1'b1;
    @(negedge clk);
    xferReq = 1'b0;
  endtask

  task automatic waitLog(input int target);
    for (int k = 0; k < 200 && logN < target; k++) @(negedge clk);
  endtask

  task automatic runSeq(input bit dir, input bit word, input bit dec,
                        input logic [23:0] start, input logic [15:0] io, input int n);
    logic [23:0] ioFull, memA, rdA, wrA, step;
    ioFull = {8'hFF, io};
    step = word ? 24'd2 : 24'd1;
    regWrite(2'd0, start);
    regWrite(2'd1, {8'h00, io});
    regWrite(2'd2, 24'(n));
    logN = 0; endPulses = 0; endDouble = 0;
    regWrite(2'd3, {20'd0, dec, word, dir, 1'b1});
    for (int i = 0; i < n; i++) begin
      pulseReq();
      waitLog(2 * (i + 1));
      repeat (2) @(negedge clk);
    end
    check(logN == 2 * n, "R7 transfer count", 32'(logN), 32'(2 * n));
    for (int i = 0; i < n; i++) begin
      memA = dec ? (start - step * 24'(i)) : (start + step * 24'(i));
      rdA = dir ? ioFull : memA;
      wrA = dir ? memA : ioFull;
      check(logWe[2*i] == 1'b0 && logWe[2*i+1] == 1'b1, "R10 read then write",
            {30'd0, logWe[2*i], logWe[2*i+1]}, 32'h1);
      check(logAddr[2*i] == rdA, dir ? "R2 R3 R4 R5 R12 source" : "R1 R4 R5 R12 source",
            {8'd0, logAddr[2*i]}, {8'd0, rdA});
      check(logAddr[2*i+1] == wrA, dir ? "R2 R4 R5 destination" : "R1 R3 destination",
            {8'd0, logAddr[2*i+1]}, {8'd0, wrA});
      if (word)
        check(logData[2*i+1] == pat(rdA), "R6 word data", {16'd0, logData[2*i+1]}, {16'd0, pat(rdA)});
      else
        check(logData[2*i+1][7:0] == pat(rdA)[7:0], "R6 byte data",
              {24'd0, logData[2*i+1][7:0]}, {24'd0, pat(rdA)[7:0]});
    end
    check(chanEn == 1'b0, "R7 enable cleared", {31'd0, chanEn}, 32'd0);
    check(endPulses == 1 && endDouble == 0, "R7 single end pulse", 32'(endPulses), 32'd1);
    pulseReq();
    repeat (10) @(negedge clk);
    check(logN == 2 * n && !busReq, "R8 request after end ignored", 32'(logN), 32'(2 * n));
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !chanEn && !xferEnd, "R11 reset state",
          {29'd0, busReq, chanEn, xferEnd}, 32'd0);

    // R8: requests with channel disabled
    regWrite(2'd2, 24'd4);
    logN = 0;
    pulseReq();
    repeat (8) @(negedge clk);
    check(logN == 0 && !busReq, "R8 disabled ignores request", 32'(logN), 32'd0);

    for (int c = 0; c < 8; c++) begin
      bit dir, word, dec;
      logic [23:0] st;
      dir = c[0]; word = c[1]; dec = c[2];
      st = dec ? 24'h000001 : (word ? 24'hFFFFFD : 24'hFFFFFE);
      runSeq(dir, word, dec, st, 16'h1230 + 16'(c), 3);
    end
    runSeq(1'b0, 1'b1, 1'b0, 24'h4A0010, 16'h0080, 1);
    runSeq(1'b1, 1'b0, 1'b1, 24'h123456, 16'hFFFE, 2);

    // R9: extra requests during a transfer collapse into one
    regWrite(2'd0, 24'h002000);
    regWrite(2'd1, 24'h000040);
    regWrite(2'd2, 24'd5);
    logN = 0;
    regWrite(2'd3, 24'h1);
    @(negedge clk); xferReq = 1'b1;
    @(negedge clk); xferReq = 1'b0;
    @(negedge clk); @(negedge clk);
    check(busReq == 1'b1, "R9 transfer running", {31'd0, busReq}, 32'd1);
    xferReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    xferReq = 1'b0;
    repeat (40) @(negedge clk);
    check(logN == 4, "R9 single pending transfer", 32'(logN), 32'd4);
    check(chanEn == 1'b1, "R9 channel still enabled", {31'd0, chanEn}, 32'd1);
    check(logAddr[2] == 24'h002001, "R9 R4 second transfer address", {8'd0, logAddr[2]}, 32'h002001);

    check(holdErrs == 0, "R10 bus cycle held until ack", 32'(holdErrs), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule